// File: doc/BRIEF.md
# Condition Register Compare Unit

This block owns a 32-bit condition register split into eight 4-bit fields, with field 0 in the most significant nibble. Bit numbering is big-endian: condition bit i sits at physical bit 31-i, and field k covers physical bits 31-4k down to 28-4k. Inside a field the weights are less-than 0x8, greater-than 0x4, equal 0x2 and summary-overflow 0x1.

An issuing pipeline presents one operation per cycle with a valid strobe. The operations are a signed or unsigned compare of a register against a second register or a 16-bit immediate, a field-masked move from a general register, a read of the whole register, a field-to-field copy, and the eight single-bit logical functions between condition bits. Separately, a completion path can update field 0 from a store-conditional success flag. Every compare and every store-conditional update folds in the sticky summary-overflow bit supplied alongside. All updates take effect on the rising clock edge.

Top module: `cr_unit`

## Requirements
- R1: A compare writes a field with exactly one of less-than (0x8), greater-than (0x4) or equal (0x2) set, and its 0x1 bit equals `so_in`. Op code 0 compares `opa` and the second operand as 32-bit two's complement values.
- R2: Op code 1 compares `opa` and the second operand as unsigned 32-bit values.
- R3: With `use_imm` high, the second operand is `imm`, sign-extended for op code 0 and zero-extended for op code 1. With `use_imm` low, it is `opb`.
- R4: A compare result goes to field `fld_dst` (k selects physical bits 31-4k..28-4k), and all other fields keep their values.
- R5: Op code 2 (masked move): for each i, `fxm[i]` high replaces physical bits 4i+3..4i with those bits of `opa`. Nibbles whose mask bit is low keep their values.
- R6: Op code 3 (read) loads `rd_data`, one edge later, with the register value held before that edge. It leaves the register unchanged. `rd_data` holds its value at all other times.
- R7: Op code 4 (field copy) copies field `fld_src` into field `fld_dst` and leaves the other fields unchanged.
- R8: Op code 5 writes physical bit 31-`bit_t` with f(bit 31-`bit_a`, bit 31-`bit_b`), where `logic_fn` selects f: 0 AND, 1 OR, 2 NAND, 3 XOR, 4 NOR, 5 equivalence, 6 a AND NOT b, 7 a OR NOT b. All other bits are unchanged.
- R9: `sc_valid` high writes field 0 as 0x2 when `sc_ok` is high, else 0x0, ORed with `so_in`.
- R10: When `sc_valid` and a valid operation fall in the same cycle, the operation's effect on fields 1 to 7 is kept and field 0 takes the store-conditional value.
- R11: With `op_valid` low, or with op codes 6 and 7, the operation has no effect on the register or `rd_data`.
- R12: A synchronous active-high `rst` clears the register and `rd_data` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation select |
| opa | input | 32 | First operand / move source |
| opb | input | 32 | Second register operand |
| imm | input | 16 | Immediate operand |
| use_imm | input | 1 | Selects the immediate as the second compare operand |
| fld_dst | input | 3 | Destination field index |
| fld_src | input | 3 | Source field index for the copy |
| fxm | input | 8 | Nibble enable mask for the masked move |
| bit_a | input | 5 | First source condition bit |
| bit_b | input | 5 | Second source condition bit |
| bit_t | input | 5 | Destination condition bit |
| logic_fn | input | 3 | Bit logic function select |
| so_in | input | 1 | Summary-overflow flag |
| sc_valid | input | 1 | Store-conditional completion strobe |
| sc_ok | input | 1 | Store-conditional success flag |
| cr_q | output | 32 | Current condition register |
| rd_data | output | 32 | Read port result |

## Verification
The store-conditional update and a pipeline operation can arrive in the same cycle, and both can target field 0. The bench raises `sc_valid` together with a compare into field 0, and again with a compare into field 3 and with a masked move that covers every nibble. It judges the outcome against a reference model in which field 0 takes the store-conditional value and the other fields take the operation's result.

// File: rtl/cr_pkg.sv
package cr_pkg;
    localparam int CR_W    = 32;
    localparam int FLD_W   = 4;
    localparam int NUM_FLD = CR_W / FLD_W;
    localparam int FIDX_W  = $clog2(NUM_FLD);
    localparam int BIDX_W  = $clog2(CR_W);
    localparam int IMM_W   = 16;

    typedef enum logic [2:0] {
        OP_CMP_S = 3'd0,
        OP_CMP_U = 3'd1,
        OP_MOVM  = 3'd2,
        OP_READ  = 3'd3,
        OP_COPY  = 3'd4,
        OP_BITL  = 3'd5
    } cr_op_e;

    typedef enum logic [2:0] {
        LF_AND  = 3'd0,
        LF_OR   = 3'd1,
        LF_NAND = 3'd2,
        LF_XOR  = 3'd3,
        LF_NOR  = 3'd4,
        LF_EQV  = 3'd5,
        LF_ANDC = 3'd6,
        LF_ORC  = 3'd7
    } cr_fn_e;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cr_fld_t;

    // ones over the nibble of field idx (field 0 is the top nibble)
    function automatic logic [CR_W-1:0] fld_mask(input logic [FIDX_W-1:0] idx);
        logic [CR_W-1:0] m;
        m = {{FLD_W{1'b1}}, {(CR_W-FLD_W){1'b0}}};
        return m >> (FLD_W * int'(idx));
    endfunction

    function automatic logic [FLD_W-1:0] fld_get(input logic [CR_W-1:0] cr,
                                                  input logic [FIDX_W-1:0] idx);
        logic [CR_W-1:0] s;
        s = cr >> (FLD_W * (NUM_FLD - 1 - int'(idx)));
        return s[FLD_W-1:0];
    endfunction

    function automatic logic bit_fn(input cr_fn_e fn, input logic a, input logic b);
        case (fn)
            LF_AND:  return a & b;
            LF_OR:   return a | b;
            LF_NAND: return ~(a & b);
            LF_XOR:  return a ^ b;
            LF_NOR:  return ~(a | b);
            LF_EQV:  return ~(a ^ b);
            LF_ANDC: return a & ~b;
            default: return a | ~b;
        endcase
    endfunction
endpackage

// File: rtl/cr_cmp.sv
module cr_cmp
    import cr_pkg::*;
#(
    parameter int DATA_W = CR_W,
    parameter int IW     = IMM_W
) (
    input  logic              is_signed,
    input  logic              use_imm,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [IW-1:0]     imm,
    input  logic              so,
    output cr_fld_t           res
);
    localparam int EXT_W = DATA_W - IW;

    logic [DATA_W-1:0] rhs;
    logic              less;

    always_comb begin
        if (!use_imm)
            rhs = b;
        else if (is_signed)
            rhs = {{EXT_W{imm[IW-1]}}, imm};
        else
            rhs = {{EXT_W{1'b0}}, imm};
    end

    always_comb begin
        if (is_signed)
            less = $signed(a) < $signed(rhs);
        else
            less = a < rhs;
        res.eq = (a == rhs);
        res.lt = less;
        res.gt = !less && (a != rhs);
        res.so = so;
    end
endmodule

// File: rtl/cr_bitop.sv
module cr_bitop
    import cr_pkg::*;
(
    input  logic [CR_W-1:0]   cr,
    input  cr_fn_e            fn,
    input  logic [BIDX_W-1:0] ba,
    input  logic [BIDX_W-1:0] bb,
    input  logic [BIDX_W-1:0] bt,
    output logic [CR_W-1:0]   cr_new
);
    logic [CR_W-1:0] cr_rev;
    logic            res;

    // big-endian view: cr_rev[i] is condition bit i
    for (genvar i = 0; i < CR_W; i++) begin : g_rev
        assign cr_rev[i] = cr[CR_W-1-i];
    end

    always_comb begin
        res    = bit_fn(fn, cr_rev[ba], cr_rev[bb]);
        cr_new = cr;
        cr_new[(CR_W-1) - int'(bt)] = res;
    end
endmodule

// File: rtl/cr_unit.sv
module cr_unit
    import cr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [CR_W-1:0]   opa,
    input  logic [CR_W-1:0]   opb,
    input  logic [IMM_W-1:0]  imm,
    input  logic              use_imm,
    input  logic [FIDX_W-1:0] fld_dst,
    input  logic [FIDX_W-1:0] fld_src,
    input  logic [NUM_FLD-1:0] fxm,
    input  logic [BIDX_W-1:0] bit_a,
    input  logic [BIDX_W-1:0] bit_b,
    input  logic [BIDX_W-1:0] bit_t,
    input  logic [2:0]        logic_fn,
    input  logic              so_in,
    input  logic              sc_valid,
    input  logic              sc_ok,
    output logic [CR_W-1:0]   cr_q,
    output logic [CR_W-1:0]   rd_data
);
    cr_op_e           op;
    cr_fld_t          cmp_res;
    logic [CR_W-1:0]  bit_res;
    logic [CR_W-1:0]  movm_mask;
    logic [CR_W-1:0]  dst_mask;
    logic [FLD_W-1:0] copy_nib;
    logic [CR_W-1:0]  cr_nxt;

    assign op = cr_op_e'(op_code);

    cr_cmp #(.DATA_W(CR_W), .IW(IMM_W)) u_cmp (
        .is_signed (op_code == OP_CMP_S),
        .use_imm   (use_imm),
        .a         (opa),
        .b         (opb),
        .imm       (imm),
        .so        (so_in),
        .res       (cmp_res)
    );

    cr_bitop u_bitop (
        .cr     (cr_q),
        .fn     (cr_fn_e'(logic_fn)),
        .ba     (bit_a),
        .bb     (bit_b),
        .bt     (bit_t),
        .cr_new (bit_res)
    );

    // mask bit i enables physical nibble 4i+3..4i
    for (genvar i = 0; i < NUM_FLD; i++) begin : g_movm
        assign movm_mask[FLD_W*i +: FLD_W] = {FLD_W{fxm[i]}};
    end

    assign dst_mask = fld_mask(fld_dst);
    assign copy_nib = fld_get(cr_q, fld_src);

    always_comb begin
        cr_nxt = cr_q;
        if (op_valid) begin
            case (op)
                OP_CMP_S, OP_CMP_U:
                    cr_nxt = (cr_q & ~dst_mask) | ({NUM_FLD{cmp_res}} & dst_mask);
                OP_MOVM:
                    cr_nxt = (cr_q & ~movm_mask) | (opa & movm_mask);
                OP_COPY:
                    cr_nxt = (cr_q & ~dst_mask) | ({NUM_FLD{copy_nib}} & dst_mask);
                OP_BITL:
                    cr_nxt = bit_res;
                default:
                    cr_nxt = cr_q;
            endcase
        end
        if (sc_valid)
            cr_nxt[CR_W-1 -: FLD_W] = {1'b0, 1'b0, sc_ok, so_in};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cr_q    <= '0;
            rd_data <= '0;
        end else begin
            cr_q <= cr_nxt;
            if (op_valid && op == OP_READ)
                rd_data <= cr_q;
        end
    end

    // R12
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (cr_q == '0 && rd_data == '0));

    // R1
    cmp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code == OP_CMP_S || op_code == OP_CMP_U)
         && !(sc_valid && fld_dst == '0))
        |=> ($countones(fld_get(cr_q, $past(fld_dst)) & 4'hE) == 1
             && fld_get(cr_q, $past(fld_dst)) [0] == $past(so_in)));

    // R9
    sc_field_chk: assert property (@(posedge clk) disable iff (rst)
        sc_valid |=> cr_q[CR_W-1 -: FLD_W] == {2'b00, $past(sc_ok), $past(so_in)});

    // R6
    read_port_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_READ) |=> rd_data == $past(cr_q));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((!op_valid || op_code == 3'd6 || op_code == 3'd7 || op_code == OP_READ)
         && !sc_valid) |=> $stable(cr_q));

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(op_valid && op_code == OP_READ) |=> $stable(rd_data));
endmodule

// File: tb/cr_unit_tb_top.sv
module cr_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [2:0]  op_code;
    logic [31:0] opa, opb;
    logic [15:0] imm;
    logic        use_imm;
    logic [2:0]  fld_dst, fld_src;
    logic [7:0]  fxm;
    logic [4:0]  bit_a, bit_b, bit_t;
    logic [2:0]  logic_fn;
    logic        so_in, sc_valid, sc_ok;
    logic [31:0] cr_q, rd_data;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_cr;
    logic [31:0] exp_rd;

    always #4 clk = ~clk;

    cr_unit dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .opa(opa), .opb(opb), .imm(imm), .use_imm(use_imm),
        .fld_dst(fld_dst), .fld_src(fld_src), .fxm(fxm),
        .bit_a(bit_a), .bit_b(bit_b), .bit_t(bit_t), .logic_fn(logic_fn),
        .so_in(so_in), .sc_valid(sc_valid), .sc_ok(sc_ok),
        .cr_q(cr_q), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic idle();
        op_valid = 0; op_code = 0; opa = 0; opb = 0; imm = 0; use_imm = 0;
        fld_dst = 0; fld_src = 0; fxm = 0; bit_a = 0; bit_b = 0; bit_t = 0;
        logic_fn = 0; so_in = 0; sc_valid = 0; sc_ok = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    function automatic logic [31:0] put_fld(input logic [31:0] cr, input int k,
                                            input logic [3:0] v);
        logic [31:0] r;
        r = cr;
        r[31-4*k -: 4] = v;
        return r;
    endfunction

    function automatic logic [3:0] cmp_ref(input logic sgn, input logic [31:0] a,
                                           input logic [31:0] b, input logic so);
        logic lt;
        lt = sgn ? ($signed(a) < $signed(b)) : (a < b);
        if (a == b) return {3'b001, so};
        return lt ? {3'b100, so} : {3'b010, so};
    endfunction

    task automatic do_cmp(input string req, input logic sgn, input logic [31:0] a,
                          input logic [31:0] b, input int k, input logic so);
        op_valid = 1; op_code = sgn ? 3'd0 : 3'd1; opa = a; opb = b;
        fld_dst = 3'(k); so_in = so;
        exp_cr = put_fld(exp_cr, k, cmp_ref(sgn, a, b, so));
        step();
        check(req, cr_q, exp_cr);
    endtask

    task automatic do_cmp_imm(input string req, input logic sgn, input logic [31:0] a,
                              input logic [15:0] iv, input int k);
        logic [31:0] ext;
        ext = sgn ? {{16{iv[15]}}, iv} : {16'h0, iv};
        op_valid = 1; op_code = sgn ? 3'd0 : 3'd1; opa = a; opb = 32'h5A5A_5A5A;
        imm = iv; use_imm = 1; fld_dst = 3'(k);
        exp_cr = put_fld(exp_cr, k, cmp_ref(sgn, a, ext, 1'b0));
        step();
        check(req, cr_q, exp_cr);
    endtask

    task automatic do_movm(input logic [31:0] src, input logic [7:0] m);
        op_valid = 1; op_code = 3'd2; opa = src; fxm = m;
        for (int i = 0; i < 8; i++)
            if (m[i]) exp_cr[4*i +: 4] = src[4*i +: 4];
        step();
        check("R5 masked move", cr_q, exp_cr);
    endtask

    task automatic do_read();
        op_valid = 1; op_code = 3'd3;
        exp_rd = exp_cr;
        step();
        check("R6 read data", rd_data, exp_rd);
        check("R6 read leaves register", cr_q, exp_cr);
    endtask

    task automatic do_copy(input int s, input int d);
        op_valid = 1; op_code = 3'd4; fld_src = 3'(s); fld_dst = 3'(d);
        exp_cr = put_fld(exp_cr, d, exp_cr[31-4*s -: 4]);
        step();
        check("R7 field copy", cr_q, exp_cr);
    endtask

    task automatic do_bitl(input int fn, input int a, input int b, input int t);
        logic x, y, r;
        x = exp_cr[31-a]; y = exp_cr[31-b];
        case (fn)
            0: r = x & y;     1: r = x | y;     2: r = !(x & y);  3: r = x ^ y;
            4: r = !(x | y);  5: r = (x == y);  6: r = x & !y;    default: r = x | !y;
        endcase
        op_valid = 1; op_code = 3'd5; logic_fn = 3'(fn);
        bit_a = 5'(a); bit_b = 5'(b); bit_t = 5'(t);
        exp_cr[31-t] = r;
        step();
        check($sformatf("R8 bit logic fn %0d", fn), cr_q, exp_cr);
    endtask

    task automatic do_sc(input logic ok, input logic so);
        sc_valid = 1; sc_ok = ok; so_in = so;
        exp_cr = put_fld(exp_cr, 0, {2'b00, ok, so});
        step();
        check("R9 store-conditional field 0", cr_q, exp_cr);
    endtask

    task automatic do_collisions();
        // compare into field 0 with store-conditional: latter owns field 0
        op_valid = 1; op_code = 3'd0; opa = 32'd1; opb = 32'd9; fld_dst = 0;
        sc_valid = 1; sc_ok = 1; so_in = 0;
        exp_cr = put_fld(exp_cr, 0, 4'h2);
        step();
        check("R10 compare field 0 vs store-conditional", cr_q, exp_cr);
        // compare into field 3 with store-conditional: both land
        op_valid = 1; op_code = 3'd1; opa = 32'd7; opb = 32'd7; fld_dst = 3;
        sc_valid = 1; sc_ok = 0; so_in = 1;
        exp_cr = put_fld(exp_cr, 3, 4'h3);
        exp_cr = put_fld(exp_cr, 0, 4'h1);
        step();
        check("R10 compare field 3 with store-conditional", cr_q, exp_cr);
        // full masked move with store-conditional
        op_valid = 1; op_code = 3'd2; opa = 32'hFEDC_BA98; fxm = 8'hFF;
        sc_valid = 1; sc_ok = 1; so_in = 1;
        exp_cr = 32'h3EDC_BA98;
        step();
        check("R10 masked move with store-conditional", cr_q, exp_cr);
    endtask

    task automatic do_ignored();
        logic [31:0] keep;
        keep = exp_cr;
        op_valid = 0; op_code = 3'd2; opa = 32'h1234_5678; fxm = 8'hFF;
        step();
        check("R11 op_valid low", cr_q, keep);
        op_valid = 1; op_code = 3'd6; opa = 32'h1234_5678; fxm = 8'hFF;
        step();
        check("R11 op code 6", cr_q, keep);
        op_valid = 1; op_code = 3'd7; opa = 32'h1234_5678;
        step();
        check("R11 op code 7", cr_q, keep);
        check("R11 rd_data held", rd_data, exp_rd);
    endtask

    initial begin
        idle();
        rst = 1;
        exp_cr = 0; exp_rd = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check("R12 reset register", cr_q, 32'h0);
        check("R12 reset read port", rd_data, 32'h0);

        do_cmp("R1 signed less", 1, 32'hFFFF_FFFB, 32'd3, 2, 0);
        do_cmp("R1 signed greater so", 1, 32'd3, 32'hFFFF_FFFB, 5, 1);
        do_cmp("R1 signed equal", 1, 32'h8000_0000, 32'h8000_0000, 7, 0);
        do_cmp("R2 unsigned greater", 0, 32'hFFFF_FFFB, 32'd3, 2, 0);
        do_cmp("R2 unsigned less so", 0, 32'd3, 32'hFFFF_FFFB, 1, 1);
        do_cmp("R4 field 0 select", 0, 32'd4, 32'd4, 0, 1);
        do_cmp_imm("R3 sign-extended imm", 1, 32'hFFFF_FFFF, 16'hFFFF, 4);
        do_cmp_imm("R3 zero-extended imm", 0, 32'hFFFF_FFFF, 16'hFFFF, 6);
        do_cmp_imm("R3 signed imm negative", 1, 32'd0, 16'h8000, 3);

        do_movm(32'h1357_9BDF, 8'b1010_0101);
        do_movm(32'hAAAA_AAAA, 8'h00);
        do_read();
        do_copy(0, 6);
        do_copy(7, 1);
        for (int f = 0; f < 8; f++) begin
            do_bitl(f, 0, 31, 14);
            do_bitl(f, 3, 16, 9);
        end
        do_sc(1, 0);
        do_sc(0, 1);
        do_collisions();
        do_read();
        do_ignored();

        op_valid = 1; op_code = 3'd2; opa = 32'hFFFF_FFFF; fxm = 8'hFF; rst = 1;
        step();
        rst = 0;
        check("R12 reset over write", cr_q, 32'h0);
        check("R12 reset clears read port", rd_data, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule